// File: doc/BRIEF.md
# Variable-Length Transform Sequencing Controller

This block is the control sequencer for a folded, bit-serial transform engine that computes 64-, 256-, 1024- or 4096-point discrete Fourier transforms on one shared set of eight-point arithmetic units. A two-bit length code is captured when a job starts. If the engine's coefficient RAM does not already hold the coefficients for that length, the controller first runs a series of coefficient load phases. In each phase it accepts a stream of partial-product words from a host and produces the RAM write strobe, the entry address and the phase index. It then runs the row pass and the column pass. Each pass is a series of iterations, and each iteration lasts one bit-serial word period. A single-cycle done pulse marks the end of the job.

The coefficient stream uses a valid/ready handshake. During loading the controller holds ready high. A word is written, and the address advances, only in a cycle where valid and ready are both high. The host may drop valid at any time to stall, and the address and phase then hold. Ready is low in every other state, so the host cannot push words while no load is running. The datapath, the coefficient values and the RAM itself are outside this block.

Top module: `vldft_seq_ctrl`

## Requirements
- R1: After reset the controller is idle. `coef_ready`, `ram_we`, `load_req`, `compute_active` and `done` are all 0. `iter_idx` and `bit_idx` are 0. No coefficients count as loaded.
- R2: The number of load phases follows `len_sel`. Code 0 gives 1 phase (64-point), code 1 gives 4 (256-point), code 2 gives 16 (1024-point) and code 3 gives 64 (4096-point). Each phase writes the 36 entries at `ram_addr` 0 to 35 in ascending order, with `ram_phase` holding the phase number. Phases run in ascending order from 0.
- R3: `coef_ready` is 1 only while loading. `ram_we` equals `coef_valid` AND `coef_ready` in every cycle. In a cycle without a write, `ram_addr` and `ram_phase` hold.
- R4: `load_req` is a one-cycle pulse in the first cycle of each load phase. In that cycle `ram_addr` is 0.
- R5: The row pass and the column pass each run 1, 8, 64 or 512 iterations for codes 0 to 3. Each iteration lasts WORD_LEN cycles, with `bit_idx` counting 0 to WORD_LEN-1 and `iter_idx` counting up from 0. `stage_col` is 0 for the row pass and 1 for the column pass.
- R6: The first row cycle follows the cycle that accepts the last coefficient word. The first column cycle follows the last row cycle. There are no idle cycles between them.
- R7: `done` is high for exactly one cycle, in the cycle right after the last column cycle. The controller is idle in the cycle after that.
- R8: A `start` with the same length code as the last complete load skips loading: the first row cycle is the cycle right after the `start` cycle.
- R9: A `start` with a different length code, or the first `start` after reset, begins a load. `load_req` is then high in the cycle right after `start`.
- R10: `start` and `len_sel` are ignored while a job runs. A pulse during a job leaves its writes, iteration counts and done timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when the controller is idle |
| len_sel | input | 2 | Transform length code, captured at start (0:64, 1:256, 2:1024, 3:4096 points) |
| coef_valid | input | 1 | Host has a coefficient word on the RAM data bus |
| coef_ready | output | 1 | Controller accepts coefficient words (load phases only) |
| load_req | output | 1 | One-cycle pulse opening each load phase |
| ram_we | output | 1 | Coefficient RAM write strobe |
| ram_phase | output | 6 | Load phase index for the current write |
| ram_addr | output | 6 | RAM entry address, 0 to 35 |
| compute_active | output | 1 | A row or column iteration runs this cycle |
| stage_col | output | 1 | 0 during the row pass, 1 during the column pass |
| iter_idx | output | 9 | Current iteration within the pass |
| bit_idx | output | 4 | Bit position within the current word period |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A wrong phase or address count shows up on the next write strobe, as an entry out of order against the expected write list, or at the end of a phase as a missing or extra `load_req`. A bad bit or iteration counter is visible in the same cycle, because every compute cycle is compared with its position in the pass. A wrong pass length moves the column start or the done pulse and is caught at that edge. A wrong record of the loaded length shows in the first cycle after `start`, as a load where a row cycle was due or the reverse.

// File: rtl/vldft_pkg.sv
package vldft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ROW,
    ST_COL,
    ST_DONE
  } seq_state_e;

  localparam int LEN_CODES = 4;

  // load phases per length code: 1, then 4 to the power of the code
  function automatic int unsigned phase_count(input int unsigned code);
    return (code == 0) ? 1 : (1 << (2 * code));
  endfunction

  // compute iterations per pass: 8 to the power of the code
  function automatic int unsigned iter_count(input int unsigned code);
    return 1 << (3 * code);
  endfunction

endpackage

// File: rtl/vldft_wrap_ctr.sv
module vldft_wrap_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= at_last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/vldft_len_decode.sv
module vldft_len_decode
  import vldft_pkg::*;
#(
  parameter int PHASE_W = 6,
  parameter int ITER_W  = 9
) (
  input  logic [1:0]         code,
  output logic [PHASE_W-1:0] phase_last,
  output logic [ITER_W-1:0]  iter_last
);
  logic [PHASE_W-1:0] ph_tab [LEN_CODES];
  logic [ITER_W-1:0]  it_tab [LEN_CODES];

  for (genvar g = 0; g < LEN_CODES; g++) begin : g_tab
    assign ph_tab[g] = PHASE_W'(phase_count(g) - 1);
    assign it_tab[g] = ITER_W'(iter_count(g) - 1);
  end

  assign phase_last = ph_tab[code];
  assign iter_last  = it_tab[code];
endmodule

// File: rtl/vldft_seq_ctrl.sv
module vldft_seq_ctrl
  import vldft_pkg::*;
#(
  parameter int ENTRIES    = 36,
  parameter int WORD_LEN   = 16,
  parameter int MAX_PHASES = 64,
  parameter int MAX_ITERS  = 512,
  localparam int ADDR_W  = $clog2(ENTRIES),
  localparam int PHASE_W = $clog2(MAX_PHASES),
  localparam int ITER_W  = $clog2(MAX_ITERS),
  localparam int BIT_W   = (WORD_LEN > 1) ? $clog2(WORD_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         len_sel,
  input  logic               coef_valid,
  output logic               coef_ready,
  output logic               load_req,
  output logic               ram_we,
  output logic [PHASE_W-1:0] ram_phase,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic               compute_active,
  output logic               stage_col,
  output logic [ITER_W-1:0]  iter_idx,
  output logic [BIT_W-1:0]   bit_idx,
  output logic               done
);
  seq_state_e state_q, state_d;
  logic [1:0] len_q, loaded_len_q;
  logic       loaded_q, load_req_q;

  logic [PHASE_W-1:0] phase_last;
  logic [ITER_W-1:0]  iter_last;
  logic addr_at_last, phase_at_last, bit_at_last, iter_at_last;

  logic in_load, in_compute, in_idle, accept, phase_done, load_fin, pass_end;
  logic go, need_load;

  assign in_idle    = (state_q == ST_IDLE);
  assign in_load    = (state_q == ST_LOAD);
  assign in_compute = (state_q == ST_ROW) || (state_q == ST_COL);
  assign accept     = in_load && coef_valid;
  assign phase_done = accept && addr_at_last;
  assign load_fin   = phase_done && phase_at_last;
  assign pass_end   = in_compute && bit_at_last && iter_at_last;
  assign go         = in_idle && start;
  assign need_load  = !loaded_q || (len_sel != loaded_len_q);

  vldft_len_decode #(.PHASE_W(PHASE_W), .ITER_W(ITER_W)) u_dec (
    .code       (len_q),
    .phase_last (phase_last),
    .iter_last  (iter_last)
  );

  vldft_wrap_ctr #(.W(ADDR_W)) u_addr (
    .clk (clk), .rst_n (rst_n), .clr (in_idle), .inc (accept),
    .last (ADDR_W'(ENTRIES - 1)), .cnt (ram_addr), .at_last (addr_at_last)
  );

  vldft_wrap_ctr #(.W(PHASE_W)) u_phase (
    .clk (clk), .rst_n (rst_n), .clr (in_idle), .inc (phase_done),
    .last (phase_last), .cnt (ram_phase), .at_last (phase_at_last)
  );

  vldft_wrap_ctr #(.W(BIT_W)) u_bit (
    .clk (clk), .rst_n (rst_n), .clr (!in_compute), .inc (in_compute),
    .last (BIT_W'(WORD_LEN - 1)), .cnt (bit_idx), .at_last (bit_at_last)
  );

  vldft_wrap_ctr #(.W(ITER_W)) u_iter (
    .clk (clk), .rst_n (rst_n), .clr (!in_compute), .inc (in_compute && bit_at_last),
    .last (iter_last), .cnt (iter_idx), .at_last (iter_at_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = need_load ? ST_LOAD : ST_ROW;
      ST_LOAD: if (load_fin) state_d = ST_ROW;
      ST_ROW:  if (pass_end) state_d = ST_COL;
      ST_COL:  if (pass_end) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      len_q        <= '0;
      loaded_q     <= 1'b0;
      loaded_len_q <= '0;
      load_req_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      load_req_q <= (go && need_load) || (phase_done && !phase_at_last);
      if (go) begin
        len_q <= len_sel;
        if (need_load) loaded_q <= 1'b0;
      end
      if (load_fin) begin
        loaded_q     <= 1'b1;
        loaded_len_q <= len_q;
      end
    end
  end

  assign coef_ready     = in_load;
  assign ram_we         = accept;
  assign load_req       = load_req_q;
  assign compute_active = in_compute;
  assign stage_col      = (state_q == ST_COL);
  assign done           = (state_q == ST_DONE);
endmodule

// File: rtl/vldft_seq_chk.sv
module vldft_seq_chk #(
  parameter int ADDR_W   = 6,
  parameter int PHASE_W  = 6,
  parameter int ITER_W   = 9,
  parameter int BIT_W    = 4,
  parameter int WORD_LEN = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               coef_valid,
  input logic               coef_ready,
  input logic               load_req,
  input logic               ram_we,
  input logic [PHASE_W-1:0] ram_phase,
  input logic [ADDR_W-1:0]  ram_addr,
  input logic               compute_active,
  input logic               stage_col,
  input logic [ITER_W-1:0]  iter_idx,
  input logic [BIT_W-1:0]   bit_idx,
  input logic               done
);
  p_we_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (coef_ready && coef_valid));

  p_no_ready_compute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    compute_active |-> !coef_ready);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_ready && !coef_valid) |=> ($stable(ram_addr) && $stable(ram_phase)));

  p_req_at_entry0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> (ram_addr == '0 && coef_ready));

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  p_bit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (compute_active && bit_idx != BIT_W'(WORD_LEN - 1)) |=>
      (compute_active && bit_idx == $past(bit_idx) + 1'b1 &&
       $stable(iter_idx) && $stable(stage_col)));

  p_col_after_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (compute_active && stage_col && !$past(stage_col)) |->
      ($past(compute_active) && iter_idx == '0 && bit_idx == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !compute_active && !coef_ready));

  p_done_after_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(compute_active) && $past(stage_col)));
endmodule

bind vldft_seq_ctrl vldft_seq_chk #(
  .ADDR_W (ADDR_W), .PHASE_W (PHASE_W), .ITER_W (ITER_W),
  .BIT_W (BIT_W), .WORD_LEN (WORD_LEN)
) u_chk (
  .clk (clk), .rst_n (rst_n), .coef_valid (coef_valid), .coef_ready (coef_ready),
  .load_req (load_req), .ram_we (ram_we), .ram_phase (ram_phase),
  .ram_addr (ram_addr), .compute_active (compute_active), .stage_col (stage_col),
  .iter_idx (iter_idx), .bit_idx (bit_idx), .done (done)
);

// File: tb/vldft_seq_ctrl_bench.sv
`timescale 1ns/100ps
module vldft_seq_ctrl_bench;
  localparam int L = 16;
  localparam int NENT = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic       coef_valid = 1'b0;
  logic       coef_ready, load_req, ram_we, compute_active, stage_col, done;
  logic [5:0] ram_phase, ram_addr;
  logic [8:0] iter_idx;
  logic [3:0] bit_idx;

  always #2.5 clk = ~clk;

  vldft_seq_ctrl u_vldft_seq_ctrl (
    .clk (clk), .rst_n (rst_n), .start (start), .len_sel (len_sel),
    .coef_valid (coef_valid), .coef_ready (coef_ready), .load_req (load_req),
    .ram_we (ram_we), .ram_phase (ram_phase), .ram_addr (ram_addr),
    .compute_active (compute_active), .stage_col (stage_col),
    .iter_idx (iter_idx), .bit_idx (bit_idx), .done (done)
  );

  int vectors = 0, miscompares = 0;
  int wq[$];
  bit mon_on = 1'b0;
  bit job_load = 1'b0;
  int job_n = 1;
  int rowpos, colpos, lreq_cnt, done_cnt;
  bit prev_we, prev_row, prev_col;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: samples 1 ns after each falling edge, before the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && mon_on) begin
      chk(ram_we === (coef_valid & coef_ready), "R3 write strobe", ram_we, coef_valid & coef_ready);
      if (ram_we) begin
        if (wq.size() == 0) chk(1'b0, "R2 unexpected write", ram_phase * 64 + ram_addr, -1);
        else begin
          int e;
          e = wq.pop_front();
          chk(ram_phase * 64 + ram_addr == e, "R2 write order", ram_phase * 64 + ram_addr, e);
        end
      end
      if (load_req) begin
        chk(ram_addr == 0 && coef_ready, "R4 request at entry 0", ram_addr, 0);
        chk(ram_phase == lreq_cnt, "R4 request phase", ram_phase, lreq_cnt);
        lreq_cnt++;
      end
      if (compute_active) begin
        chk(!coef_ready, "R3 ready low in compute", coef_ready, 0);
        if (!stage_col) begin
          if (rowpos == 0 && job_load) chk(prev_we, "R6 row right after last write", prev_we, 1);
          chk(iter_idx == rowpos / L, "R5 row iteration", iter_idx, rowpos / L);
          chk(bit_idx == rowpos % L, "R5 row bit", bit_idx, rowpos % L);
          rowpos++;
        end else begin
          if (colpos == 0)
            chk(prev_row && rowpos == job_n * L, "R6 column right after row", rowpos, job_n * L);
          chk(iter_idx == colpos / L, "R5 column iteration", iter_idx, colpos / L);
          chk(bit_idx == colpos % L, "R5 column bit", bit_idx, colpos % L);
          colpos++;
        end
      end
      if (done) begin
        chk(prev_col && colpos == job_n * L && !compute_active, "R7 done after last column",
            colpos, job_n * L);
        done_cnt++;
      end
      prev_we  = ram_we;
      prev_row = compute_active && !stage_col;
      prev_col = compute_active && stage_col;
    end
  end

  function automatic logic vpat(input int cyc, input int stall_mod);
    return (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
  endfunction

  // driver: pushes the expected writes, then runs one job
  task automatic run_job(input logic [1:0] code, input bit exp_load,
                         input int stall_mod, input bit poke);
    int nph, cyc;
    nph = (code == 0) ? 1 : (1 << (2 * code));
    job_n = 1 << (3 * code);
    job_load = exp_load;
    if (exp_load)
      for (int p = 0; p < nph; p++)
        for (int a = 0; a < NENT; a++) wq.push_back(p * 64 + a);
    rowpos = 0; colpos = 0; lreq_cnt = 0; done_cnt = 0;
    prev_we = 0; prev_row = 0; prev_col = 0;
    @(negedge clk);
    len_sel = code; start = 1'b1; coef_valid = 1'b0;
    @(negedge clk);
    start = 1'b0; coef_valid = vpat(0, stall_mod);
    #2;
    if (exp_load) chk(load_req && coef_ready, "R9 load follows start", load_req, 1);
    else chk(compute_active && !stage_col && iter_idx == 0 && bit_idx == 0,
             "R8 row follows start", compute_active, 1);
    cyc = 1;
    while (done_cnt == 0 && cyc < 40000) begin
      @(negedge clk);
      coef_valid = vpat(cyc, stall_mod);
      start   = poke && (cyc == 40 || cyc == 60);
      len_sel = (poke && (cyc == 40 || cyc == 60)) ? ~code : code;
      cyc++;
    end
    coef_valid = 1'b0; start = 1'b0; len_sel = code;
    #2;
    chk(!compute_active && !coef_ready && !done, "R7 idle after done", compute_active, 0);
    chk(wq.size() == 0, "R2 all writes seen", wq.size(), 0);
    chk(lreq_cnt == (exp_load ? nph : 0), "R2 phase count", lreq_cnt, exp_load ? nph : 0);
    chk(rowpos == job_n * L, "R5 row pass length", rowpos, job_n * L);
    chk(colpos == job_n * L, "R5 column pass length", colpos, job_n * L);
    chk(done_cnt == 1, poke ? "R10 start ignored while busy" : "R7 one done pulse", done_cnt, 1);
    wq.delete();
  endtask

  task automatic apply_reset();
    mon_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!coef_ready && !ram_we && !load_req && !compute_active && !done &&
        iter_idx == 0 && bit_idx == 0, "R1 reset state", compute_active, 0);
    mon_on = 1'b1;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    apply_reset();
    run_job(2'd0, 1'b1, 0, 1'b0);   // R2 first load, 1 phase
    run_job(2'd0, 1'b0, 0, 1'b0);   // R8 same length, no load
    run_job(2'd1, 1'b1, 3, 1'b0);   // R9 new length, R3 stalls
    run_job(2'd1, 1'b0, 0, 1'b1);   // R10 pokes during compute
    run_job(2'd2, 1'b1, 5, 1'b1);   // R10 pokes during load
    run_job(2'd3, 1'b1, 0, 1'b0);   // R2 64 phases, R5 512 iterations
    run_job(2'd3, 1'b0, 0, 1'b0);
    run_job(2'd1, 1'b1, 2, 1'b0);   // R9 shorter length reloads
    apply_reset();
    run_job(2'd1, 1'b1, 0, 1'b0);   // R1 reset forgets loaded length
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule